// File: doc/BRIEF.md
# Configurable Logic Cell with Edge Interrupts

This block is a small programmable logic element. Four single-bit gate inputs feed a function selected by a 3-bit mode field: three purely combinational functions (AND-OR, OR-XOR, four-input AND) and five stateful ones (set/reset latch, two D-type flops, a JK flop and a transparent latch). The result passes through an optional inversion controlled by a separate input. It is then gated by the cell enable and driven out as the cell output, together with a pin-enable signal.

An 8-bit control register holds the enable, the pin-enable, two interrupt arming bits and the mode. On read-back, the live cell output is merged into the register image. A sticky interrupt flag is set when the cell output makes an armed rising or falling transition. A clear pulse from software resets the flag. The block has no streaming data path. Every pin is a plain control or status signal, so no valid/ready handshake applies and no back-pressure exists.

All stateful modes run on the system clock. A "clock edge" on gate input g1 is seen when g1 is sampled high at one system clock edge after being sampled low at the edge before. Set and reset act at the next system clock edge, regardless of g1. Combinational modes reach the output in the same cycle. Stateful modes reach it one system clock edge after their inputs are sampled.

Top module: `cfg_logic_cell`

## Requirements
- R1: After reset, reg_rdata is 8'h00, and cell_out, pin_oe and irq_flag are 0.
- R2: A reg_wr write loads the control register at the next clock edge. The layout is: bit 7 enable, bit 6 pin enable, bit 4 rising-edge arm, bit 3 falling-edge arm, bits 2:0 mode. Written bit 5 is ignored. Read bit 5 always shows the live cell_out.
- R3: With enable 0, cell_out is 0. The stateful element clears at the next clock edge, so re-enabling a stateful mode without set or reset input shows 0.
- R4: pin_oe equals control bit 6.
- R5: With g1..g4 = gate_in[0..3], the combinational modes are: mode 000 gives (g1&g2)|(g3&g4); mode 001 gives (g1|g2)^(g3|g4); mode 010 gives g1&g2&g3&g4. These reach cell_out in the same cycle.
- R6: Mode 011 is a set/reset latch with set = g1|g2 and reset = g3|g4. Reset wins over set. Otherwise the state holds.
- R7: Mode 100 is a D flop. On a g1 rise it loads g2. g3 sets it, g4 resets it, and reset wins over set, which wins over the clock.
- R8: Mode 101 is a D flop. On a g1 rise it loads g2^g4. g3 resets it.
- R9: Mode 110 is a JK flop with J = g2 and K = g4, acting on a g1 rise: 10 sets, 01 clears, 11 toggles, 00 holds. g3 resets it.
- R10: Mode 111 is a latch. While g1 is high the state follows g2. g3 sets it and g4 resets it, and reset wins.
- R11: pol_inv = 1 inverts the function result ahead of cell_out, read bit 5 and edge detection.
- R12: irq_flag sets one clock edge after cell_out rises (with bit 4 armed) or falls (with bit 3 armed). It then stays set.
- R13: An irq_clr pulse clears irq_flag at the next edge. An armed edge in that same cycle keeps the flag set.
- R14: A mode change sets irq_flag only if cell_out changes level as a result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register image with live output in bit 5 |
| irq_clr | input | 1 | Pulse that clears the interrupt flag |
| pol_inv | input | 1 | Inverts the function result |
| gate_in | input | 4 | Gate inputs g1..g4 (bit 0 = g1) |
| cell_out | output | 1 | Cell output |
| pin_oe | output | 1 | Pin output enable |
| irq_flag | output | 1 | Sticky edge interrupt flag |

## Verification
The block is fixed at four gates and an 8-bit control word. The bench therefore builds it with the package defaults only. That single build reaches every mode encoding, both interrupt arms and the polarity stage. The checks focus on the orderings: reset over set over clock in the stateful modes, state clearing on disable, a clear colliding with an edge, and mode switches that do or do not move the output level.

// File: rtl/clc_pkg.sv
package clc_pkg;
  localparam int CTRL_W  = 8;
  localparam int MODE_W  = 3;
  localparam int N_GATE  = 4;
  localparam int EN_BIT  = 7;
  localparam int OE_BIT  = 6;
  localparam int OUT_BIT = 5;
  localparam int RIE_BIT = 4;
  localparam int FIE_BIT = 3;
  localparam logic [CTRL_W-1:0] WR_MASK = ~(CTRL_W'(1) << OUT_BIT);

  typedef enum logic [MODE_W-1:0] {
    M_AND_OR   = 3'd0,
    M_OR_XOR   = 3'd1,
    M_AND4     = 3'd2,
    M_SR       = 3'd3,
    M_DFF_SR   = 3'd4,
    M_DFF2_R   = 3'd5,
    M_JK_R     = 3'd6,
    M_LATCH_SR = 3'd7
  } cell_mode_e;

  function automatic logic mode_is_seq(cell_mode_e m);
    return (m == M_SR) || m[MODE_W-1];
  endfunction
endpackage

// File: rtl/clc_ctrl_reg.sv
module clc_ctrl_reg
  import clc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [CTRL_W-1:0] wdata,
  input  logic              live_out,
  output logic [CTRL_W-1:0] rdata,
  output logic              en,
  output logic              oe,
  output logic              rise_arm,
  output logic              fall_arm,
  output cell_mode_e        mode
);
  logic [CTRL_W-1:0] ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  ctrl_q <= '0;
    else if (wr) ctrl_q <= wdata & WR_MASK;
  end

  assign rdata    = ctrl_q | (CTRL_W'(live_out) << OUT_BIT);
  assign en       = ctrl_q[EN_BIT];
  assign oe       = ctrl_q[OE_BIT];
  assign rise_arm = ctrl_q[RIE_BIT];
  assign fall_arm = ctrl_q[FIE_BIT];
  assign mode     = cell_mode_e'(ctrl_q[MODE_W-1:0]);

  // R2
  wr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (ctrl_q == ($past(wdata) & WR_MASK)));
  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(ctrl_q));
endmodule

// File: rtl/clc_comb_fn.sv
module clc_comb_fn
  import clc_pkg::*;
(
  input  cell_mode_e        mode,
  input  logic [N_GATE-1:0] g,
  output logic              res
);
  always_comb begin
    case (mode)
      M_AND_OR: res = (g[0] & g[1]) | (g[2] & g[3]);
      M_OR_XOR: res = (g[0] | g[1]) ^ (g[2] | g[3]);
      M_AND4:   res = &g;
      default:  res = 1'b0;
    endcase
  end
endmodule

// File: rtl/clc_seq_fn.sv
module clc_seq_fn
  import clc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  cell_mode_e        mode,
  input  logic [N_GATE-1:0] g,
  output logic              q
);
  logic g1_q;
  logic g1_rise;
  logic q_nxt;

  assign g1_rise = g[0] & ~g1_q;

  always_comb begin
    q_nxt = q;
    if (!en) begin
      q_nxt = 1'b0;
    end else begin
      case (mode)
        M_SR: begin
          if (g[2] | g[3])      q_nxt = 1'b0;
          else if (g[0] | g[1]) q_nxt = 1'b1;
        end
        M_DFF_SR: begin
          if (g[3])         q_nxt = 1'b0;
          else if (g[2])    q_nxt = 1'b1;
          else if (g1_rise) q_nxt = g[1];
        end
        M_DFF2_R: begin
          if (g[2])         q_nxt = 1'b0;
          else if (g1_rise) q_nxt = g[1] ^ g[3];
        end
        M_JK_R: begin
          if (g[2]) q_nxt = 1'b0;
          else if (g1_rise) begin
            case ({g[1], g[3]})
              2'b10:   q_nxt = 1'b1;
              2'b01:   q_nxt = 1'b0;
              2'b11:   q_nxt = ~q;
              default: q_nxt = q;
            endcase
          end
        end
        M_LATCH_SR: begin
          if (g[3])      q_nxt = 1'b0;
          else if (g[2]) q_nxt = 1'b1;
          else if (g[0]) q_nxt = g[1];
        end
        default: q_nxt = q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      g1_q <= 1'b0;
      q    <= 1'b0;
    end else begin
      g1_q <= g[0];
      q    <= q_nxt;
    end
  end

  // R3
  disable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !q);
  // R6
  sr_reset_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode == M_SR && (g[2] || g[3])) |=> !q);
  // R9
  jk_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode == M_JK_R && !g[2] && g[0] && !g1_q && g[1] && g[3]) |=> (q != $past(q)));
  // R7
  dff_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode == M_DFF_SR && !g[2] && !g[3] && !(g[0] && !g1_q)) |=> $stable(q));
endmodule

// File: rtl/clc_edge_irq.sv
module clc_edge_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  input  logic rise_arm,
  input  logic fall_arm,
  input  logic clr,
  output logic flag
);
  logic prev_q;
  logic hit;

  assign hit = (rise_arm & level & ~prev_q) | (fall_arm & ~level & prev_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      flag   <= 1'b0;
    end else begin
      prev_q <= level;
      if (hit)      flag <= 1'b1;
      else if (clr) flag <= 1'b0;
    end
  end

  // R12
  rise_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_arm && $rose(level)) |=> flag);
  // R12
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);
  // R13
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && $stable(level)) |=> !flag);
  // R14
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag && level == prev_q) |=> !flag);
endmodule

// File: rtl/cfg_logic_cell.sv
module cfg_logic_cell
  import clc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [CTRL_W-1:0] reg_wdata,
  output logic [CTRL_W-1:0] reg_rdata,
  input  logic              irq_clr,
  input  logic              pol_inv,
  input  logic [N_GATE-1:0] gate_in,
  output logic              cell_out,
  output logic              pin_oe,
  output logic              irq_flag
);
  logic       en, rise_arm, fall_arm;
  cell_mode_e mode;
  logic       comb_res, seq_q, fn_res;

  clc_ctrl_reg u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (reg_wr),
    .wdata    (reg_wdata),
    .live_out (cell_out),
    .rdata    (reg_rdata),
    .en       (en),
    .oe       (pin_oe),
    .rise_arm (rise_arm),
    .fall_arm (fall_arm),
    .mode     (mode)
  );

  clc_comb_fn u_comb (
    .mode (mode),
    .g    (gate_in),
    .res  (comb_res)
  );

  clc_seq_fn u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .mode  (mode),
    .g     (gate_in),
    .q     (seq_q)
  );

  assign fn_res   = mode_is_seq(mode) ? seq_q : comb_res;
  assign cell_out = en & (fn_res ^ pol_inv);

  clc_edge_irq u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .level    (cell_out),
    .rise_arm (rise_arm),
    .fall_arm (fall_arm),
    .clr      (irq_clr),
    .flag     (irq_flag)
  );

  // R3
  off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !cell_out);
  // R5
  and4_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !pol_inv && mode == M_AND4 && cell_out) |-> (&gate_in));
  // R2
  readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[OUT_BIT] == cell_out);
  // R4
  oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pin_oe == reg_rdata[OE_BIT]);
endmodule

// File: tb/cfg_logic_cell_tb.sv
module cfg_logic_cell_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       irq_clr = 1'b0;
  logic       pol_inv = 1'b0;
  logic [3:0] gate_in = 4'h0;
  logic       cell_out, pin_oe, irq_flag;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] ctrl_m = 8'h00;

  string       req_q[$];
  logic [10:0] val_q[$];

  always #2 clk = ~clk;

  cfg_logic_cell u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_clr(irq_clr), .pol_inv(pol_inv),
    .gate_in(gate_in), .cell_out(cell_out), .pin_oe(pin_oe), .irq_flag(irq_flag)
  );

  task automatic ex(input string r, input logic o, input logic f);
    req_q.push_back(r);
    val_q.push_back({o, ctrl_m[6], f, ctrl_m[7:6], o, ctrl_m[4:0]});
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk); reg_wr = 1'b1; reg_wdata = v;
    @(negedge clk); reg_wr = 1'b0;
    ctrl_m = v & 8'hDF;
  endtask

  task automatic setg(input logic [3:0] g);
    @(negedge clk); gate_in = g;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic clr();
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
  endtask

  task automatic setpol(input logic p);
    @(negedge clk); pol_inv = p;
  endtask

  // monitor: pop expectations and compare away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (val_q.size() > 0) begin
        string       r;
        logic [10:0] e;
        logic [10:0] a;
        r = req_q.pop_front();
        e = val_q.pop_front();
        a = {cell_out, pin_oe, irq_flag, reg_rdata};
        checks++;
        if (a !== e) begin
          errors++;
          $display("FAIL %s actual out=%b oe=%b irq=%b rd=%h expected out=%b oe=%b irq=%b rd=%h",
                   r, a[10], a[9], a[8], a[7:0], e[10], e[9], e[8], e[7:0]);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    ex("R1 reset", 0, 0);

    // R5 combinational modes
    wr(8'h80);          ex("R5 and-or idle", 0, 0);
    setg(4'b0011);      ex("R5 and-or g1g2", 1, 0);
    setg(4'b1100);      ex("R5 and-or g3g4", 1, 0);
    setg(4'b0101);      ex("R5 and-or cross", 0, 0);
    wr(8'h81);          ex("R5 or-xor both", 0, 0);
    setg(4'b0001);      ex("R5 or-xor left", 1, 0);
    setg(4'b1000);      ex("R5 or-xor right", 1, 0);
    setg(4'b1001);      ex("R5 or-xor equal", 0, 0);
    wr(8'h82);          ex("R5 and4 partial", 0, 0);
    setg(4'b1111);      ex("R5 and4 all", 1, 0);
    setg(4'b0111);      ex("R5 and4 three", 0, 0);
    // R4 pin enable
    wr(8'hC2);          ex("R4 oe on", 0, 0);
    wr(8'h82);          ex("R4 oe off", 0, 0);
    // R2 bit 5 ignored on write, live on read
    wr(8'hA2);          ex("R2 bit5 write ignored", 0, 0);
    setg(4'b1111);      ex("R2 bit5 live", 1, 0);
    // R3 disabled
    wr(8'h02);          ex("R3 disabled low", 0, 0);
    // R11 polarity
    setpol(1'b1);       ex("R11 pol while disabled", 0, 0);
    wr(8'h82);          ex("R11 pol inverts 1", 0, 0);
    setg(4'b0000);      ex("R11 pol inverts 0", 1, 0);
    setpol(1'b0);       ex("R11 pol off", 0, 0);

    // R12 / R13 interrupts
    wr(8'h92);          ex("R12 arm rise", 0, 0);
    setg(4'b1111);      ex("R12 rise pending", 1, 0);
    tick();             ex("R12 rise flag", 1, 1);
    setg(4'b0000);      ex("R12 sticky", 0, 1);
    clr();              ex("R13 clear", 0, 0);
    wr(8'h8A);          ex("R12 arm fall", 0, 0);
    setg(4'b1111);      tick(); ex("R12 rise unarmed", 1, 0);
    setg(4'b0000);      ex("R12 fall pending", 0, 0);
    tick();             ex("R12 fall flag", 0, 1);
    wr(8'h9A);          ex("R12 arm both", 0, 1);
    @(negedge clk); gate_in = 4'b1111; irq_clr = 1'b1;
    ex("R13 collide", 1, 1);
    @(negedge clk); irq_clr = 1'b0;
    ex("R13 edge wins", 1, 1);
    clr();              ex("R13 clear again", 1, 0);
    // R14 mode change
    wr(8'h98);          ex("R14 same level", 1, 0);
    tick();             ex("R14 no flag", 1, 0);
    wr(8'h99);          ex("R14 level drop", 0, 0);
    tick();             ex("R14 flag on change", 0, 1);
    clr();              ex("R14 clear", 0, 0);

    // R6 SR latch
    wr(8'h83);          ex("R6 reset held", 0, 0);
    setg(4'b0011); tick(); ex("R6 set", 1, 0);
    setg(4'b0000); tick(); ex("R6 hold", 1, 0);
    setg(4'b1000); tick(); ex("R6 reset", 0, 0);
    setg(4'b1001); tick(); ex("R6 reset wins", 0, 0);
    // R3 state cleared on disable
    setg(4'b0001); tick(); ex("R3 set before off", 1, 0);
    setg(4'b0000); tick(); ex("R3 hold before off", 1, 0);
    wr(8'h03);          ex("R3 off", 0, 0);
    tick();             ex("R3 off hold", 0, 0);
    wr(8'h83);          ex("R3 state cleared", 0, 0);

    // R7 D flop set/reset
    wr(8'h84);          ex("R7 idle", 0, 0);
    setg(4'b0010); tick(); ex("R7 no clock", 0, 0);
    setg(4'b0011); tick(); ex("R7 load 1", 1, 0);
    setg(4'b0001); tick(); ex("R7 level no load", 1, 0);
    setg(4'b0000); tick(); ex("R7 fall no load", 1, 0);
    setg(4'b0001); tick(); ex("R7 load 0", 0, 0);
    setg(4'b0100); tick(); ex("R7 set", 1, 0);
    setg(4'b1100); tick(); ex("R7 reset wins", 0, 0);
    setg(4'b0000);
    // R8 D flop xor input
    wr(8'h85);          ex("R8 idle", 0, 0);
    setg(4'b0010); tick(); ex("R8 no clock", 0, 0);
    setg(4'b0011); tick(); ex("R8 load 1^0", 1, 0);
    setg(4'b0100); tick(); ex("R8 reset", 0, 0);
    setg(4'b1000);
    setg(4'b1001); tick(); ex("R8 load 0^1", 1, 0);
    setg(4'b1000);
    setg(4'b1011); tick(); ex("R8 load 1^1", 0, 0);
    setg(4'b0010);
    setg(4'b0011); tick(); ex("R8 reload", 1, 0);
    setg(4'b0111); tick(); ex("R8 reset g3", 0, 0);
    // R9 JK
    wr(8'h86);          ex("R9 idle", 0, 0);
    setg(4'b0000);
    setg(4'b0010);
    setg(4'b0011); tick(); ex("R9 J set", 1, 0);
    setg(4'b1010); tick(); ex("R9 no clock", 1, 0);
    setg(4'b1011); tick(); ex("R9 toggle low", 0, 0);
    setg(4'b1010);
    setg(4'b1011); tick(); ex("R9 toggle high", 1, 0);
    setg(4'b0000);
    setg(4'b0001); tick(); ex("R9 hold", 1, 0);
    setg(4'b1000);
    setg(4'b1001); tick(); ex("R9 K clear", 0, 0);
    setg(4'b0010);
    setg(4'b0011); tick(); ex("R9 J again", 1, 0);
    setg(4'b0110); tick(); ex("R9 reset", 0, 0);
    // R10 latch
    setg(4'b0000);
    wr(8'h87);          ex("R10 idle", 0, 0);
    setg(4'b0011); tick(); ex("R10 follow 1", 1, 0);
    setg(4'b0001); tick(); ex("R10 follow 0", 0, 0);
    setg(4'b0010); tick(); ex("R10 closed", 0, 0);
    setg(4'b0100); tick(); ex("R10 set", 1, 0);
    setg(4'b1100); tick(); ex("R10 reset wins", 0, 0);

    // R11 polarity feeds edge detection
    setg(4'b0000);
    wr(8'h90);          ex("R11 armed", 0, 0);
    setpol(1'b1);       ex("R11 pol rise", 1, 0);
    tick();             ex("R11 pol edge flag", 1, 1);

    tick(); tick();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule